// File: doc/BRIEF.md
# Output Impedance Code Updater

This controller maintains the drive-strength code of an output buffer so that the buffer's impedance follows a target set by an external precision resistor. The target impedance is one fifth of the resistor value. An analog comparator outside the block reports whether the driver is currently too weak or too strong. A clock divider produces periodic update ticks. On each tick the code moves by exactly one step toward the target, so the buffer output never sees a large disturbance. A higher code means a stronger driver, which gives a lower impedance.

The updater runs on the main clock alone. It has no input for memory activity, so read, write, deselect and output-enable state have no effect on it, and updates stop only if the clock stops. At reset, and when the device wakes from sleep, the code loads a mid-scale value that corresponds to roughly 50 ohms. A board strap forces the strongest setting. Oscillation around the target is detected and reported as lock. After each reversal the code pauses for one tick to limit dithering. A separate ready flag rises once a programmable dwell of clock cycles has elapsed after reset, and normal operation may begin from that point.

With the default divide ratio of 256, moving from mid-scale to either end of the range takes about 32 ticks, or roughly 8,200 cycles. This is inside the 4,000 to 16,000 cycle settling window.

Top module: `imp_code_ctrl`

## Requirements
- R1: The code changes only on an update tick. Ticks occur every DIV_RATIO clock edges, and the first occurs on edge DIV_RATIO after reset is released. The strap and wake inputs are the exception.
- R2: On a tick that is not a pause tick, `cmp_weak_i`=1 raises the code by one and `cmp_weak_i`=0 lowers it by one.
- R3: Between two consecutive clock edges the code never changes by more than one step unless `force_min_i` or `wake_i` was high.
- R4: Reset loads code 2^(CODE_W-1), which is 32 by default, and clears lock. A wake pulse sampled high does the same on the next edge, and the following tick is not treated as a reversal.
- R5: While `force_min_i` is sampled high, the code is 2^CODE_W-1 (63 by default) from the next edge onward, and lock is low. After release, stepping resumes from that value.
- R6: The code saturates at 0 and at 2^CODE_W-1. A request to step past either end leaves the code unchanged.
- R7: `locked_o` rises on a tick whose comparator direction is opposite to that of the previous stepping tick. That tick still takes its step, and the next tick takes no step.
- R8: `locked_o` falls on a stepping tick whose direction repeats the previous one.
- R9: `ready_o` is low from reset until DWELL_CYCLES clock edges have passed, then stays high. Wake and strap do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_weak_i | input | 1 | Comparator result: 1 means the driver is too weak, 0 means too strong |
| force_min_i | input | 1 | Strap: force the minimum-impedance (strongest) code |
| wake_i | input | 1 | Sleep-recovery pulse; reloads the mid-scale code |
| code_o | output | CODE_W | Current drive-strength code |
| locked_o | output | 1 | Comparator direction has reversed; code is at the target |
| ready_o | output | 1 | Power-up dwell has elapsed |

## Verification
The assertions check on every cycle that the code moves only on ticks and by at most one step. They also check that the strap and wake values take effect on the next edge, that ready never falls, and that lock changes only on ticks or override edges. Only the bench scenarios can show the step direction chosen for each comparator value and the exact tick timing. The same holds for saturation at both ends, the pause tick after a reversal, the lock-clearing rule, the forgetting of direction history after wake or strap, and the exact dwell length.

// File: rtl/imp_code_pkg.sv
package imp_code_pkg;
  typedef enum logic {
    DIR_DN = 1'b0,
    DIR_UP = 1'b1
  } step_dir_e;
endpackage

// File: rtl/imp_tick_div.sv
module imp_tick_div #(
  parameter int DIV_RATIO = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV_RATIO <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV_RATIO);
      localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + CW'(1);
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/imp_dwell_timer.sv
module imp_dwell_timer #(
  parameter int DWELL_CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int CW = $clog2(DWELL_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DWELL_CYCLES);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
  end

  assign ready_o = (cnt_q == LIMIT);
endmodule

// File: rtl/imp_code_stepper.sv
module imp_code_stepper
  import imp_code_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmp_weak_i,
  input  logic              force_min_i,
  input  logic              wake_i,
  output logic [CODE_W-1:0] code_o,
  output logic              locked_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] code_q, code_d;
  logic              locked_q, locked_d;
  logic              hold_q, hold_d;
  logic              prev_vld_q, prev_vld_d;
  step_dir_e         prev_dir_q, prev_dir_d;
  step_dir_e         dir;

  assign dir = cmp_weak_i ? DIR_UP : DIR_DN;

  always_comb begin
    code_d     = code_q;
    locked_d   = locked_q;
    hold_d     = hold_q;
    prev_vld_d = prev_vld_q;
    prev_dir_d = prev_dir_q;
    if (force_min_i || wake_i) begin
      code_d     = force_min_i ? CODE_MAX : CODE_MID;
      locked_d   = 1'b0;
      hold_d     = 1'b0;
      prev_vld_d = 1'b0;
    end else if (tick_i) begin
      if (hold_q) begin
        hold_d = 1'b0;  // pause tick after a reversal
      end else begin
        if (dir == DIR_UP && code_q != CODE_MAX)   code_d = code_q + CODE_W'(1);
        else if (dir == DIR_DN && code_q != '0)    code_d = code_q - CODE_W'(1);
        if (prev_vld_q && dir != prev_dir_q) begin
          locked_d = 1'b1;
          hold_d   = 1'b1;
        end else if (prev_vld_q) begin
          locked_d = 1'b0;
        end
        prev_vld_d = 1'b1;
        prev_dir_d = dir;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q     <= CODE_MID;
      locked_q   <= 1'b0;
      hold_q     <= 1'b0;
      prev_vld_q <= 1'b0;
      prev_dir_q <= DIR_DN;
    end else begin
      code_q     <= code_d;
      locked_q   <= locked_d;
      hold_q     <= hold_d;
      prev_vld_q <= prev_vld_d;
      prev_dir_q <= prev_dir_d;
    end
  end

  assign code_o   = code_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/imp_code_ctrl.sv
module imp_code_ctrl #(
  parameter int CODE_W       = 6,
  parameter int DIV_RATIO    = 256,
  parameter int DWELL_CYCLES = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_weak_i,
  input  logic              force_min_i,
  input  logic              wake_i,
  output logic [CODE_W-1:0] code_o,
  output logic              locked_o,
  output logic              ready_o
);
  logic tick;

  imp_tick_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  imp_code_stepper #(.CODE_W(CODE_W)) u_step (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .cmp_weak_i  (cmp_weak_i),
    .force_min_i (force_min_i),
    .wake_i      (wake_i),
    .code_o      (code_o),
    .locked_o    (locked_o)
  );

  imp_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_dwell (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_o (ready_o)
  );
endmodule

// File: rtl/imp_code_ctrl_chk.sv
module imp_code_ctrl_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              cmp_weak_i,
  input logic              force_min_i,
  input logic              wake_i,
  input logic [CODE_W-1:0] code_o,
  input logic              locked_o,
  input logic              ready_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);

  AST_HOLD_OFF_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !force_min_i && !wake_i) |=> $stable(code_o)); // R1

  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_min_i && !wake_i) |=> (code_o == $past(code_o) ||
      code_o == $past(code_o) + CODE_W'(1) || code_o == $past(code_o) - CODE_W'(1))); // R3

  AST_WAKE_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !force_min_i) |=> (code_o == CODE_MID && !locked_o)); // R4

  AST_FORCE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_min_i |=> (code_o == CODE_MAX && !locked_o)); // R5

  AST_LOCK_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !force_min_i && !wake_i) |=> $stable(locked_o)); // R7

  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R9
endmodule

bind imp_code_ctrl imp_code_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick),
  .cmp_weak_i  (cmp_weak_i),
  .force_min_i (force_min_i),
  .wake_i      (wake_i),
  .code_o      (code_o),
  .locked_o    (locked_o),
  .ready_o     (ready_o)
);

// File: tb/imp_code_ctrl_tb.sv
module imp_code_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int CODE_W = 6;
  localparam int DIV    = 8;
  localparam int DWELL  = 100;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmp_weak = 1'b0;
  logic              force_min = 1'b0;
  logic              wake = 1'b0;
  logic [CODE_W-1:0] code;
  logic              locked;
  logic              ready;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  imp_code_ctrl #(.CODE_W(CODE_W), .DIV_RATIO(DIV), .DWELL_CYCLES(DWELL)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmp_weak_i  (cmp_weak),
    .force_min_i (force_min),
    .wake_i      (wake),
    .code_o      (code),
    .locked_o    (locked),
    .ready_o     (ready)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // stop at the negedge right after the next tick edge
  task automatic next_tick();
    @(negedge clk);
    while (cyc % DIV != 0) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R4 reset code", int'(code), 32);
    check("R4 reset lock", int'(locked), 0);
    check("R9 ready low after reset", int'(ready), 0);
  endtask

  task automatic t_step_up();
    cmp_weak = 1'b1;
    while (cyc != DIV - 1) @(negedge clk);
    check("R1 no change before first tick", int'(code), 32);
    next_tick();
    check("R1 first tick step", int'(code), 33);
    check("R2 up no lock", int'(locked), 0);
    for (int i = 0; i < 3; i++) next_tick();
    check("R2 up steps", int'(code), 36);
  endtask

  task automatic t_reverse();
    cmp_weak = 1'b0;
    next_tick();
    check("R7 reversal step", int'(code), 35);
    check("R7 lock rises", int'(locked), 1);
    next_tick();
    check("R7 pause tick", int'(code), 35);
    next_tick();
    check("R2 down step", int'(code), 34);
    check("R8 lock falls on repeat", int'(locked), 0);
  endtask

  task automatic t_ready();
    while (cyc != DWELL - 1) @(negedge clk);
    check("R9 ready low before dwell", int'(ready), 0);
    @(negedge clk);
    check("R9 ready high at dwell", int'(ready), 1);
  endtask

  task automatic t_sat_low();
    cmp_weak = 1'b0;
    for (int i = 0; i < 40; i++) next_tick();
    check("R6 saturate at zero", int'(code), 0);
    check("R8 no lock while saturated", int'(locked), 0);
  endtask

  task automatic t_force();
    force_min = 1'b1;
    @(negedge clk);
    check("R5 forced max", int'(code), 63);
    check("R5 forced lock low", int'(locked), 0);
    repeat (2) @(negedge clk);
    force_min = 1'b0;
    cmp_weak = 1'b1;
    next_tick();
    check("R6 saturate at max", int'(code), 63);
    check("R5 no lock after release", int'(locked), 0);
    cmp_weak = 1'b0;
    next_tick();
    check("R5 resume from max", int'(code), 62);
    check("R7 lock after release", int'(locked), 1);
    next_tick();
    check("R7 pause after lock", int'(code), 62);
  endtask

  task automatic t_wake();
    while (cyc % DIV != 2) @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    check("R4 wake mid code", int'(code), 32);
    check("R4 wake lock clear", int'(locked), 0);
    check("R9 ready kept on wake", int'(ready), 1);
    cmp_weak = 1'b0;
    next_tick();
    check("R4 history cleared", int'(code), 31);
    check("R4 no lock after wake", int'(locked), 0);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R4 async reset code", int'(code), 32);
    check("R9 ready cleared by reset", int'(ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_step_up();
    t_reverse();
    t_ready();
    t_sat_low();
    t_force();
    t_wake();
    t_reset_again();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule